// File: doc/BRIEF.md
# Wide-to-Dual-Stream Ping-Pong Splitter

This block accepts a 512-bit input stream in whole 4 KB blocks and spreads those blocks over two buffer banks. The first block goes to bank 0, the second to bank 1, and so on in strict turn. Each bank stores up to four complete blocks in its own slots. It plays them out as an independent 256-bit stream with a valid/ready handshake, so a stalled consumer on one stream never holds up the other stream's output.

When the bank due for the next block has no free slot, input ready is held low, even if the other bank has free slots. Blocks are never diverted, so the order of blocks on each stream is fixed. A slot is released only once the last beat of its block has been taken by the consumer, and that output then pulses a block-done flag.

Top module: `wide_split_pingpong`

## Requirements
- R1: After reset, `in_ready` is 1, both stream valids are 0 and both block-done flags are 0.
- R2: Input blocks of 64 accepted beats are routed alternately: block 0 to stream 0, block 1 to stream 1, block 2 to stream 0, and so on.
- R3: Each accepted 512-bit beat appears on its stream as two 256-bit beats, bits 255:0 first and bits 511:256 second, and a block's 128 output beats keep input order.
- R4: A stored block's first output beat is valid in the cycle right after the cycle in which that block's 64th input beat was accepted.
- R5: Each bank holds at most four unread blocks. When the bank due next holds four, `in_ready` is 0 whatever the state of the other bank.
- R6: Once the first beat of a block has been accepted, `in_ready` stays 1 until that block's 64th beat has been accepted.
- R7: A stream's block-done flag is 1 for exactly one cycle, the cycle after the 128th beat of a block was accepted on that stream. The slot counts as free from that same cycle.
- R8: Holding one stream's ready at 0 does not stop the other stream from delivering its stored blocks.
- R9: While a stream's valid is 1 and its ready is 0, valid stays 1 and the data stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 512 | Input beat |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Bank due next can take the beat |
| s0_data | output | 256 | Stream 0 beat |
| s0_valid | output | 1 | Stream 0 beat present |
| s0_ready | input | 1 | Stream 0 consumer takes the beat |
| s0_blk_done | output | 1 | Stream 0 finished a block (one-cycle pulse) |
| s1_data | output | 256 | Stream 1 beat |
| s1_valid | output | 1 | Stream 1 beat present |
| s1_ready | input | 1 | Stream 1 consumer takes the beat |
| s1_blk_done | output | 1 | Stream 1 finished a block (one-cycle pulse) |

## Verification
A wrong slot count shows at the ports within one cycle. It either drops `in_ready` while the due bank still has room, or keeps it high when that bank is full. It can also leave a stream valid after its last block has drained. A slipped read or write pointer shows up on the first output beat of the affected block, as data from the wrong block or the wrong half of a beat. A selector that fails to alternate sends the next block to the wrong stream, and that is visible as soon as the block becomes valid one cycle after its last input beat. The bench predicts each of these per cycle from queues of expected words, so any of these faults is caught in the cycle it first reaches a port.

// File: rtl/splt_pkg.sv
package splt_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/splt_fill_ctl.sv
// Chooses the bank for incoming blocks and counts beats inside a block.
module splt_fill_ctl
  import splt_pkg::*;
#(
  parameter int IN_BEATS = 64,
  localparam int BW = $clog2(IN_BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    bank_free,
  output logic          in_ready,
  output bank_e         sel,
  output logic [BW-1:0] beat,
  output logic [1:0]    wr_en,
  output logic          wr_last
);
  function automatic logic is_final(input logic [BW-1:0] b);
    return b == BW'(IN_BEATS - 1);
  endfunction

  logic fire;

  // no fallback to the other bank: strict turn order
  assign in_ready = bank_free[sel];
  assign fire     = in_valid && in_ready;
  assign wr_last  = is_final(beat);

  for (genvar g = 0; g < 2; g++) begin : g_wen
    assign wr_en[g] = fire && (sel == bank_e'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= BANK_A;
      beat <= '0;
    end else if (fire) begin
      if (wr_last) begin
        beat <= '0;
        sel  <= other_bank(sel);
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/splt_slot_tracker.sv
// Ring of block slots: write pointer, read pointer and filled count.
module splt_slot_tracker #(
  parameter int SLOTS = 4,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [SW-1:0] wr_slot,
  output logic [SW-1:0] rd_slot,
  output logic [CW-1:0] count,
  output logic          has_free,
  output logic          has_data
);
  function automatic logic [SW-1:0] bump(input logic [SW-1:0] p);
    if (p == SW'(SLOTS - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign has_free = count < CW'(SLOTS);
  assign has_data = count != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot <= '0;
      rd_slot <= '0;
      count   <= '0;
    end else begin
      if (push) wr_slot <= bump(wr_slot);
      if (pop)  rd_slot <= bump(rd_slot);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/splt_bank.sv
// One buffer bank: slot storage written wide, read out narrow.
module splt_bank #(
  parameter int IN_W     = 512,
  parameter int OUT_W    = 256,
  parameter int IN_BEATS = 64,
  parameter int SLOTS    = 4,
  localparam int RATIO     = IN_W / OUT_W,
  localparam int OUT_BEATS = IN_BEATS * RATIO,
  localparam int BW        = $clog2(IN_BEATS),
  localparam int LW        = $clog2(RATIO),
  localparam int RBW       = $clog2(OUT_BEATS),
  localparam int SW        = $clog2(SLOTS),
  localparam int CW        = $clog2(SLOTS + 1),
  localparam int DEPTH     = SLOTS * IN_BEATS,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_beat,
  input  logic             wr_last,
  input  logic [IN_W-1:0]  wr_data,
  output logic             free,
  output logic [CW-1:0]    count,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_blk_done,
  output logic             rd_end
);
  function automatic logic [AW-1:0] word_addr(input logic [SW-1:0] s,
                                              input logic [BW-1:0] w);
    return AW'(s) * AW'(IN_BEATS) + AW'(w);
  endfunction

  function automatic logic [OUT_W-1:0] lane_pick(input logic [IN_W-1:0] word,
                                                 input logic [LW-1:0] lane);
    return word[lane*OUT_W +: OUT_W];
  endfunction

  logic [IN_W-1:0] mem [DEPTH];
  logic [SW-1:0]   wr_slot, rd_slot;
  logic [RBW-1:0]  rd_beat;
  logic            rd_fire, push;

  splt_slot_tracker #(.SLOTS(SLOTS)) u_trk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(rd_end),
    .wr_slot(wr_slot), .rd_slot(rd_slot), .count(count),
    .has_free(free), .has_data(out_valid)
  );

  assign push     = wr_en && wr_last;
  assign rd_fire  = out_valid && out_ready;
  assign rd_end   = rd_fire && (rd_beat == RBW'(OUT_BEATS - 1));
  assign out_data = lane_pick(mem[word_addr(rd_slot, rd_beat[RBW-1:LW])],
                              rd_beat[LW-1:0]);

  always_ff @(posedge clk) begin
    if (wr_en) mem[word_addr(wr_slot, wr_beat)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_beat      <= '0;
      out_blk_done <= 1'b0;
    end else begin
      out_blk_done <= rd_end;
      if (rd_fire) rd_beat <= rd_end ? '0 : rd_beat + 1'b1;
    end
  end
endmodule

// File: rtl/wide_split_pingpong.sv
module wide_split_pingpong
  import splt_pkg::*;
#(
  parameter int IN_W     = 512,
  parameter int OUT_W    = 256,
  parameter int IN_BEATS = 64,
  parameter int SLOTS    = 4,
  localparam int BW = $clog2(IN_BEATS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [OUT_W-1:0] s0_data,
  output logic             s0_valid,
  input  logic             s0_ready,
  output logic             s0_blk_done,
  output logic [OUT_W-1:0] s1_data,
  output logic             s1_valid,
  input  logic             s1_ready,
  output logic             s1_blk_done
);
  // internal events, also observed by the bound checker
  bank_e                  fill_sel;
  logic [BW-1:0]          fill_beat;
  logic [1:0]             wr_en;
  logic                   wr_last;
  logic [1:0]             bank_free, bank_valid, bank_ready, bank_done, rd_end;
  logic [1:0][OUT_W-1:0]  bank_data;
  logic [1:0][CW-1:0]     bank_cnt;

  splt_fill_ctl #(.IN_BEATS(IN_BEATS)) u_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bank_free(bank_free),
    .in_ready(in_ready), .sel(fill_sel), .beat(fill_beat),
    .wr_en(wr_en), .wr_last(wr_last)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    splt_bank #(.IN_W(IN_W), .OUT_W(OUT_W), .IN_BEATS(IN_BEATS), .SLOTS(SLOTS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[b]), .wr_beat(fill_beat), .wr_last(wr_last), .wr_data(in_data),
      .free(bank_free[b]), .count(bank_cnt[b]),
      .out_data(bank_data[b]), .out_valid(bank_valid[b]), .out_ready(bank_ready[b]),
      .out_blk_done(bank_done[b]), .rd_end(rd_end[b])
    );
  end

  assign bank_ready  = {s1_ready, s0_ready};
  assign s0_data     = bank_data[0];
  assign s0_valid    = bank_valid[0];
  assign s0_blk_done = bank_done[0];
  assign s1_data     = bank_data[1];
  assign s1_valid    = bank_valid[1];
  assign s1_blk_done = bank_done[1];
endmodule

// File: rtl/splt_checker.sv
module splt_checker #(
  parameter int OUT_W    = 256,
  parameter int IN_BEATS = 64,
  parameter int SLOTS    = 4,
  localparam int BW = $clog2(IN_BEATS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               fill_sel,
  input logic [BW-1:0]      fill_beat,
  input logic [1:0]         wr_en,
  input logic               wr_last,
  input logic [1:0][CW-1:0] bank_cnt,
  input logic [OUT_W-1:0]   s0_data,
  input logic               s0_valid,
  input logic               s0_ready,
  input logic               s0_blk_done,
  input logic [OUT_W-1:0]   s1_data,
  input logic               s1_valid,
  input logic               s1_ready,
  input logic               s1_blk_done
);
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_cnt[0] <= CW'(SLOTS)) && (bank_cnt[1] <= CW'(SLOTS))); // R5
  AST_MIDBLK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_beat != '0) |-> in_ready); // R6
  AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_en) && wr_last) |=> (fill_sel != $past(fill_sel))); // R2
  AST_FILL_SHOWS0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && wr_last) |=> s0_valid); // R4
  AST_FILL_SHOWS1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[1] && wr_last) |=> s1_valid); // R4
  AST_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_valid && !s0_ready) |=> (s0_valid && $stable(s0_data))); // R9
  AST_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_ready) |=> (s1_valid && $stable(s1_data))); // R9
  AST_DONE_PULSE0: assert property (@(posedge clk) disable iff (!rst_n)
    s0_blk_done |=> !s0_blk_done); // R7
  AST_DONE_PULSE1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_blk_done |=> !s1_blk_done); // R7
endmodule

bind wide_split_pingpong splt_checker #(
  .OUT_W(OUT_W), .IN_BEATS(IN_BEATS), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .fill_sel(fill_sel),
  .fill_beat(fill_beat), .wr_en(wr_en), .wr_last(wr_last), .bank_cnt(bank_cnt),
  .s0_data(s0_data), .s0_valid(s0_valid), .s0_ready(s0_ready), .s0_blk_done(s0_blk_done),
  .s1_data(s1_data), .s1_valid(s1_valid), .s1_ready(s1_ready), .s1_blk_done(s1_blk_done)
);

// File: tb/sim_wide_split_pingpong.sv
module sim_wide_split_pingpong;
  localparam int IN_W = 512, OUT_W = 256, BLK_IN = 64, BLK_OUT = 128, SLOTS = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [IN_W-1:0]  in_data;
  logic             in_valid, in_ready;
  logic [OUT_W-1:0] s0_data, s1_data;
  logic             s0_valid, s1_valid, s0_ready, s1_ready, s0_blk_done, s1_blk_done;

  wide_split_pingpong u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .s0_data(s0_data), .s0_valid(s0_valid), .s0_ready(s0_ready), .s0_blk_done(s0_blk_done),
    .s1_data(s1_data), .s1_valid(s1_valid), .s1_ready(s1_ready), .s1_blk_done(s1_blk_done)
  );

  int n_chk = 0, n_fail = 0;

  // reference model: committed words per stream, staging for the block being filled
  typedef logic [OUT_W-1:0] word_q_t [$];
  word_q_t          mq [2];
  word_q_t          stg;
  int               m_sel = 0, m_beat = 0, serial = 0;
  bit               exp_done [2];
  bit               hold [2];
  logic [OUT_W-1:0] hold_data [2];
  int               s0_taken = 0;

  task automatic chk(input bit ok, input string tag, input logic [OUT_W-1:0] act,
                     input logic [OUT_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [IN_W-1:0] make_word(input int n);
    logic [31:0] lo, hi;
    lo = 32'(n * 2);
    hi = 32'(n * 2 + 1);
    return {{8{hi}}, {8{lo}}};
  endfunction

  function automatic int blocks_held(input int b);
    return (mq[b].size() + BLK_OUT - 1) / BLK_OUT;
  endfunction

  task automatic step(input int pv, input int pr0, input int pr1);
    logic [OUT_W-1:0] a_data [2];
    logic             a_valid [2], a_done [2], rdy [2];
    bit               exp_rdy, acc;
    @(negedge clk);
    a_data[0] = s0_data;  a_valid[0] = s0_valid;  a_done[0] = s0_blk_done;
    a_data[1] = s1_data;  a_valid[1] = s1_valid;  a_done[1] = s1_blk_done;
    exp_rdy = blocks_held(m_sel) < SLOTS;
    chk(in_ready == exp_rdy, "R5/R6 in_ready", OUT_W'(in_ready), OUT_W'(exp_rdy));
    for (int b = 0; b < 2; b++) begin
      bit ev;
      ev = mq[b].size() != 0;
      chk(a_valid[b] == ev, $sformatf("R4 stream%0d valid", b), OUT_W'(a_valid[b]), OUT_W'(ev));
      if (ev && a_valid[b])
        chk(a_data[b] == mq[b][0], $sformatf("R2/R3 stream%0d data", b), a_data[b], mq[b][0]);
      chk(a_done[b] == exp_done[b], $sformatf("R7 stream%0d blk_done", b),
          OUT_W'(a_done[b]), OUT_W'(exp_done[b]));
      if (hold[b]) begin
        chk(a_valid[b] == 1'b1, $sformatf("R9 stream%0d valid held", b), OUT_W'(a_valid[b]), 1);
        chk(a_data[b] == hold_data[b], $sformatf("R9 stream%0d data held", b), a_data[b], hold_data[b]);
      end
    end
    // drive next inputs
    in_valid = ($urandom_range(99) < pv);
    s0_ready = ($urandom_range(99) < pr0);
    s1_ready = ($urandom_range(99) < pr1);
    in_data  = make_word(serial);
    rdy[0] = s0_ready;  rdy[1] = s1_ready;
    // advance model to the state after the coming edge
    for (int b = 0; b < 2; b++) begin
      bit ev;
      ev = mq[b].size() != 0;
      acc = ev && rdy[b];
      hold[b] = ev && !rdy[b];
      hold_data[b] = ev ? mq[b][0] : '0;
      exp_done[b] = acc && (mq[b].size() % BLK_OUT == 1);
      if (acc) begin
        void'(mq[b].pop_front());
        if (b == 0) s0_taken++;
      end
    end
    if (in_valid && exp_rdy) begin
      stg.push_back(in_data[OUT_W-1:0]);
      stg.push_back(in_data[IN_W-1:OUT_W]);
      serial++;
      m_beat++;
      if (m_beat == BLK_IN) begin
        foreach (stg[i]) mq[m_sel].push_back(stg[i]);
        stg.delete();
        m_beat = 0;
        m_sel = 1 - m_sel;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; s0_ready = 1'b0; s1_ready = 1'b0;
    exp_done[0] = 0; exp_done[1] = 0; hold[0] = 0; hold[1] = 0;
    hold_data[0] = '0; hold_data[1] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready after reset", OUT_W'(in_ready), 1);
    chk(s0_valid == 1'b0, "R1 s0_valid after reset", OUT_W'(s0_valid), 0);
    chk(s1_valid == 1'b0, "R1 s1_valid after reset", OUT_W'(s1_valid), 0);
    chk({s0_blk_done, s1_blk_done} == 2'b00, "R1 blk_done after reset",
        OUT_W'({s0_blk_done, s1_blk_done}), 0);

    // full-rate streaming on all sides
    repeat (1500) step(100, 100, 100);

    // stream 1 stalled: stream 0 keeps draining (R8), input blocks on the full bank (R5)
    s0_taken = 0;
    repeat (1500) step(100, 100, 0);
    chk(s0_taken > 0, "R8 stream0 drains while stream1 stalled", OUT_W'(s0_taken), 1);
    chk(in_ready == 1'b0, "R5 stall on full bank with other bank empty", OUT_W'(in_ready), 0);
    chk(s0_valid == 1'b0, "R5 other bank empty during stall", OUT_W'(s0_valid), 0);
    chk(s1_valid == 1'b1, "R5 full bank still holds data", OUT_W'(s1_valid), 1);

    // irregular traffic on every port
    repeat (4000) step(70, 60, 40);
    repeat (3000) step(95, 30, 90);

    // drain
    repeat (800) step(0, 100, 100);
    @(negedge clk);
    chk(s0_valid == 1'b0 && s1_valid == 1'b0, "R7 all slots released after drain",
        OUT_W'({s0_valid, s1_valid}), 0);
    chk(in_ready == 1'b1, "R7 input ready once slots freed", OUT_W'(in_ready), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule